// File: doc/BRIEF.md
# One-Hot Control Step Sequencer

This block is a hardwired control unit in which every control step is a single flip-flop and a single active bit travels along the chain. The first step is a wait step: the chain parks there after reset and after a halt, and it leaves only when a clean start pulse arrives. From there, control passes step by step through the main sequence. One step is a two-way branch steered by a condition input. The last step is the halt step, which sends control back to the wait step. Nothing else in the block is cleared by a halt.

Two helpers sit in front of the chain. The first is a power-on stretcher that holds the sequencer in reset for a set number of clocks after the power-on input falls. The second is a start conditioner that turns a raw push-button level into a pulse one clock wide. A button that is still held down when a fast sequence halts therefore cannot start the sequence again.

Top module: `ctl_sequencer`

## Requirements
- R1: `step_vec` always has exactly one bit set outside reset. `step_idx` is the binary position of that bit: bit 0, code 0, is the wait step. `onehot_err` is 0 whenever the vector is one-hot.
- R2: At any clock edge where the sequence reset (`pwr_on`, `por_hold` or `rst`) is high, `step_vec` becomes 1, whichever step was active before.
- R3: The wait step holds while `start_pulse` is 0. At an edge where `start_pulse` is 1, control moves to step code 1.
- R4: Step code k moves to k+1 at the next edge for every k from 1 to NSTEPS-2, except the branch step.
- R5: The branch step (code BR_STEP) moves to the halt step NSTEPS-1 if `cond_in` is 1 at the edge, and to BR_STEP+1 otherwise.
- R6: The halt step (code NSTEPS-1) returns control to code 0 one edge later. The halt does not reset the start conditioner or the power-on stretcher, so a button held through a whole run causes no second run.
- R7: `start_pulse` is high in the cycle after an edge at which the button was sampled 1 and the previous sample was 0. It is therefore one clock wide per press.
- R8: During the sequence reset, the conditioner is loaded as if the button were pressed. A button held across a reset produces no pulse until it is released and pressed again.
- R9: `pwr_on` high clears the power-on counter and sets `por_hold`. After `pwr_on` falls, `por_hold` stays 1 for exactly POR_CYCLES edges and then drops to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_on | input | 1 | Power-on input, active high, synchronous |
| rst | input | 1 | External control reset, active high, synchronous |
| start_btn | input | 1 | Raw start push-button level |
| cond_in | input | 1 | Condition for the branch step |
| step_vec | output | NSTEPS | One-hot control step vector |
| step_idx | output | IDX_W | Binary index of the active step |
| start_pulse | output | 1 | Conditioned one-clock start pulse |
| por_hold | output | 1 | Power-on stretcher still holding reset |
| onehot_err | output | 1 | Step vector is not one-hot |

## Verification
The hardest case to reach from the ports is a reset that lands on each individual step, including the halt step and both sides of the branch. The stimulus starts a run, follows a cycle-accurate reference of the step index, and raises `rst` for one clock exactly when the index reaches the chosen step. This is repeated for every step with the branch condition both set and clear. A button held through a full run, and a button held across a reset, cover the false-restart cases.

// File: rtl/ctlseq_pkg.sv
package ctlseq_pkg;
  // width of a binary counter or index covering n values, never below 1
  function automatic int unsigned w_of(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ctlseq_por.sv
module ctlseq_por #(
  parameter int unsigned POR_CYCLES = 16
) (
  input  logic clk,
  input  logic pwr_on,
  output logic hold
);
  localparam int unsigned CW = ctlseq_pkg::w_of(POR_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(POR_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (pwr_on) begin
      cnt  <= '0;
      hold <= 1'b1;
    end else if (hold) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) hold <= 1'b0;
    end
  end

  assert_por_set_R9: assert property (@(posedge clk) pwr_on |=> hold);
endmodule

// File: rtl/ctlseq_startgen.sv
module ctlseq_startgen (
  input  logic clk,
  input  logic rst,
  input  logic btn,
  output logic pulse
);
  logic smp_a, smp_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_a <= 1'b1;   // act as if pressed: a held button cannot fire
      smp_b <= 1'b1;
    end else begin
      smp_a <= btn;
      smp_b <= smp_a;
    end
  end

  assign pulse = smp_a & ~smp_b;

  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/ctlseq_chain.sv
module ctlseq_chain #(
  parameter int unsigned NSTEPS  = 8,
  parameter int unsigned BR_STEP = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              cond,
  output logic [NSTEPS-1:0] q
);
  localparam int unsigned HALT = NSTEPS - 1;

  logic [NSTEPS-1:0] nxt;

  for (genvar i = 0; i < NSTEPS; i++) begin : g_step
    if (i == 0) begin : g_wait
      assign nxt[i] = (q[0] & ~go) | q[HALT];
    end else if (i == 1) begin : g_first
      assign nxt[i] = q[0] & go;
    end else if (i == BR_STEP + 1) begin : g_fall
      assign nxt[i] = q[BR_STEP] & ~cond;
    end else if (i == HALT) begin : g_halt
      assign nxt[i] = q[i-1] | (q[BR_STEP] & cond);
    end else begin : g_lin
      assign nxt[i] = q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= NSTEPS'(1);
    else     q <= nxt;
  end

  assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot(q));
  assert_wait_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (q[0] && !go) |=> q[0]);
  assert_wait_go_R3: assert property (@(posedge clk) disable iff (rst)
    (q[0] && go) |=> q[1]);
  assert_linear_R4: assert property (@(posedge clk) disable iff (rst)
    q[1] |=> q[2]);
  assert_branch_take_R5: assert property (@(posedge clk) disable iff (rst)
    (q[BR_STEP] && cond) |=> q[HALT]);
  assert_branch_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (q[BR_STEP] && !cond) |=> q[BR_STEP+1]);
  assert_halt_ret_R6: assert property (@(posedge clk) disable iff (rst)
    q[HALT] |=> q[0]);
endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer #(
  parameter int unsigned NSTEPS     = 8,
  parameter int unsigned BR_STEP    = 3,
  parameter int unsigned POR_CYCLES = 16,
  localparam int unsigned IDX_W     = ctlseq_pkg::w_of(NSTEPS)
) (
  input  logic              clk,
  input  logic              pwr_on,
  input  logic              rst,
  input  logic              start_btn,
  input  logic              cond_in,
  output logic [NSTEPS-1:0] step_vec,
  output logic [IDX_W-1:0]  step_idx,
  output logic              start_pulse,
  output logic              por_hold,
  output logic              onehot_err
);
  localparam int unsigned CNT_W = ctlseq_pkg::w_of(NSTEPS + 1);

  logic seq_rst;

  ctlseq_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .pwr_on(pwr_on), .hold(por_hold)
  );

  assign seq_rst = pwr_on | por_hold | rst;

  ctlseq_startgen u_start (
    .clk(clk), .rst(seq_rst), .btn(start_btn), .pulse(start_pulse)
  );

  ctlseq_chain #(.NSTEPS(NSTEPS), .BR_STEP(BR_STEP)) u_chain (
    .clk(clk), .rst(seq_rst), .go(start_pulse), .cond(cond_in), .q(step_vec)
  );

  // binary encoder and population check of the step register
  always_comb begin
    logic [CNT_W-1:0] ones;
    step_idx = '0;
    ones     = '0;
    for (int i = 0; i < NSTEPS; i++) begin
      if (step_vec[i]) begin
        step_idx = step_idx | IDX_W'(i);
        ones     = ones + 1'b1;
      end
    end
    onehot_err = (ones != CNT_W'(1));
  end

  assert_reset_R2: assert property (@(posedge clk) disable iff (pwr_on)
    seq_rst |=> (step_vec == NSTEPS'(1)));
  assert_no_err_R1: assert property (@(posedge clk) disable iff (seq_rst)
    !onehot_err);
endmodule

// File: tb/sim_ctl_sequencer.sv
module sim_ctl_sequencer;
  localparam int CLK_T = 10;
  localparam int N     = 8;
  localparam int BR    = 3;
  localparam int POR   = 16;
  localparam int IW    = 3;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic pwr_on = 1'b1, rst = 1'b0, start_btn = 1'b0, cond_in = 1'b0;
  logic [N-1:0]  step_vec;
  logic [IW-1:0] step_idx;
  logic start_pulse, por_hold, onehot_err;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state, updated per edge from the requirement text
  int  m_idx = 0;
  bit  m_a = 1, m_b = 1, m_hold = 1;
  int  m_cnt = 0;

  always #(CLK_T/2) clk = ~clk;

  ctl_sequencer #(.NSTEPS(N), .BR_STEP(BR), .POR_CYCLES(POR)) u0 (
    .clk(clk), .pwr_on(pwr_on), .rst(rst), .start_btn(start_btn),
    .cond_in(cond_in), .step_vec(step_vec), .step_idx(step_idx),
    .start_pulse(start_pulse), .por_hold(por_hold), .onehot_err(onehot_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: advance reference with the inputs seen at the edge, then compare
  task automatic tick();
    bit r, p;
    int ni;
    @(posedge clk);
    r = pwr_on || m_hold || rst;
    p = m_a && !m_b;
    if (r) ni = 0;
    else if (m_idx == 0) ni = p ? 1 : 0;
    else if (m_idx == BR) ni = cond_in ? N-1 : BR+1;
    else if (m_idx == N-1) ni = 0;
    else ni = m_idx + 1;
    m_idx = ni;
    if (r) begin m_a = 1; m_b = 1; end
    else begin m_b = m_a; m_a = start_btn; end
    if (pwr_on) begin m_hold = 1; m_cnt = 0; end
    else if (m_hold) begin
      if (m_cnt == POR-1) m_hold = 0;
      m_cnt++;
    end
    #1;
    chk("R1 step_idx (R2/R3/R4/R5/R6)", int'(step_idx), m_idx);
    chk("R1 step_vec", int'(step_vec), 1 << m_idx);
    chk("R1 onehot_err", int'(onehot_err), 0);
    chk("R7 start_pulse (R8)", int'(start_pulse), int'(m_a && !m_b));
    chk("R9 por_hold", int'(por_hold), int'(m_hold));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic press();
    start_btn = 1'b1; ticks(2);
    start_btn = 1'b0; ticks(2);
  endtask

  initial begin
    ticks(3);                       // R9: power-on held
    pwr_on = 1'b0;
    ticks(POR + 3);                 // R9: stretch then release
    ticks(10);                      // R3: idle wait with no press
    chk("R3 still waiting", int'(step_idx), 0);

    // R3 R4 R5: fall-through path, then R5 taken path to halt R6
    for (int c = 0; c < 2; c++) begin
      cond_in = c[0];
      press();
      ticks(12);
      chk("R6 back in wait", int'(step_idx), 0);
    end

    // R6 R7: button held through a whole run, no second run
    cond_in = 1'b1;
    start_btn = 1'b1;
    ticks(40);
    chk("R6 no false restart", int'(step_idx), 0);
    start_btn = 1'b0; ticks(3);

    // R2: reset landing on every step, both branch settings
    for (int c = 0; c < 2; c++) begin
      for (int tgt = 1; tgt < N; tgt++) begin
        cond_in = c[0];
        start_btn = 1'b1; tick();
        start_btn = 1'b0;
        for (int g = 0; g < 20 && m_idx != tgt; g++) tick();
        if (m_idx == tgt) begin
          rst = 1'b1; tick();
          chk("R2 reset from step", int'(step_idx), 0);
          rst = 1'b0;
        end
        ticks(N + 2);
      end
    end

    // R8: button held across a reset gives no pulse
    cond_in = 1'b0;
    start_btn = 1'b1; rst = 1'b1; ticks(3);
    rst = 1'b0; ticks(6);
    chk("R8 held through reset", int'(step_idx), 0);
    start_btn = 1'b0; ticks(2);
    press(); ticks(10);

    // R9: power-on again mid-run
    press();
    pwr_on = 1'b1; ticks(2);
    pwr_on = 1'b0; ticks(POR + 4);
    press(); ticks(12);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_T * LIMIT);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule